// File: doc/BRIEF.md
# UART Host Register Bank

This block is the byte-wide register file that a host processor sees in a classic single-channel UART. The host reaches it through a plain synchronous bus: one access per clock, with a select, a write flag, a 3-bit offset and a byte of write data. Read data is combinational from the current offset and state. Read side effects, such as clearing flags, take effect at the clock edge that ends the access.

The bank holds the following state:
- a 16-bit baud divisor;
- interrupt enable bits;
- line control and modem control settings;
- a scratch byte;
- the receive buffer and the line status flags.

A divisor-access bit in the line control register redirects offsets 0 and 1 from the data buffer and the interrupt enables to the two divisor bytes.

Bytes written for transmission are trimmed to the programmed character length and passed to a separate serializer with a one-cycle load pulse. The serializer reports that the shift is complete. Received characters arrive from a deserializer together with their error flags and land in the receive buffer.

Top module: `uart_regbank`

## Requirements
- R1: After reset the line status reads 0x60, offset 2 reads 0x01, and every other offset reads 0x00. `tx_load`, `tx_err`, `divisor`, `line_ctrl` and `modem_ctrl` are all 0.
- R2: When line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. `divisor` is {high, low}. When bit 7 is 0, the divisor is not reachable at those offsets.
- R3: Line control (offset 3) reads back all 8 bits as written. Modem control (offset 4) keeps bits 4:0 and reads 0 above them. Interrupt enable (offset 1, divisor access off) keeps bits 3:0 and reads 0 above them.
- R4: Offset 7 is a scratch byte that reads back what was last written.
- R5: A write to offset 0 with divisor access off, while line status bit 5 (holding empty) is 1, is accepted. The next cycle shows a one-cycle `tx_load` with `tx_byte`, and it clears line status bits 5 and 6.
- R6: The transmitted byte is the written byte ANDed with 0xFF >> (3 − line control bits 1:0).
- R7: A transmit write while bit 5 is 0 is dropped: no `tx_load`, and `tx_err` is high for one cycle, the cycle after the write.
- R8: A `tx_done` pulse sets line status bits 5 and 6.
- R9: `rx_valid` stores `rx_byte` for reading at offset 0 (divisor access off). It sets bit 0 (data ready) and loads bits 2 and 3 from `rx_perr` and `rx_ferr`. `rx_brk` sets bit 4.
- R10: Reading offset 0 with divisor access off clears bit 0. A read at offset 0 with divisor access on leaves it set.
- R11: `rx_valid` while bit 0 is set and the buffer is not being read in that cycle sets bit 1 (overrun). Reading the line status clears bits 1 and 4 and keeps bits 2 and 3.
- R12: Writes to offsets 2, 5 and 6 change nothing. Offset 6 always reads 0x00.
- R13: When an arrival meets a clearing read in the same cycle, the arrival wins. Data ready stays 1 and holds the new byte, with no overrun. A break set in the same cycle as a line status read survives that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_sel | input | 1 | Bus access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current offset |
| tx_load | output | 1 | One-cycle load strobe to the serializer |
| tx_byte | output | 8 | Masked transmit byte |
| tx_err | output | 1 | One-cycle pulse: transmit write dropped |
| tx_done | input | 1 | Serializer finished the character |
| rx_valid | input | 1 | Received character present |
| rx_byte | input | 8 | Received character |
| rx_perr | input | 1 | Parity error of the character |
| rx_ferr | input | 1 | Framing error of the character |
| rx_brk | input | 1 | Break detected |
| line_ctrl | output | 8 | Line control register contents |
| modem_ctrl | output | 5 | Modem control register contents |
| divisor | output | 16 | Baud divisor |

## Verification
The functions most likely to collide are a character arriving from the deserializer and a host read that clears the very flags the arrival sets. The bench raises `rx_valid` in the same cycle as a host read of the receive buffer. It then checks that data ready stays set, that the new byte is readable and that no overrun is flagged. It repeats the collision with a break arriving during a line status read and checks that the break bit survives.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int IEN_W  = 4;
  localparam int MCR_W  = 5;
  localparam int DIV_W  = 2 * DATA_W;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_IID  = 3'd2,
    OFS_LCR  = 3'd3,
    OFS_MCR  = 3'd4,
    OFS_LSR  = 3'd5,
    OFS_MSR  = 3'd6,
    OFS_SCR  = 3'd7
  } ofs_e;

  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       pen;
    logic       stop;
    logic [1:0] wls;
  } lcr_t;

  localparam logic [DATA_W-1:0] IID_IDLE = 8'h01;

  // Character mask: 5 + wls data bits
  function automatic logic [DATA_W-1:0] char_mask(input logic [1:0] wls);
    return 8'hFF >> (2'd3 - wls);
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  output logic              st_thr,
  output logic              st_dlo,
  output logic              st_dhi,
  output logic              st_ien,
  output logic              st_lcr,
  output logic              st_mcr,
  output logic              st_scr,
  output logic              ld_rbr,
  output logic              ld_lsr
);
  logic wr, rd;
  ofs_e ofs;

  assign wr  = acc_en & wr_en;
  assign rd  = acc_en & ~wr_en;
  assign ofs = ofs_e'(addr);

  always_comb begin
    st_thr = 1'b0;
    st_dlo = 1'b0;
    st_dhi = 1'b0;
    st_ien = 1'b0;
    st_lcr = 1'b0;
    st_mcr = 1'b0;
    st_scr = 1'b0;
    ld_rbr = 1'b0;
    ld_lsr = 1'b0;
    case (ofs)
      OFS_DATA: begin
        st_thr = wr & ~dlab;
        st_dlo = wr & dlab;
        ld_rbr = rd & ~dlab;
      end
      OFS_IEN: begin
        st_ien = wr & ~dlab;
        st_dhi = wr & dlab;
      end
      OFS_LCR: st_lcr = wr;
      OFS_MCR: st_mcr = wr;
      OFS_LSR: ld_lsr = rd;
      OFS_SCR: st_scr = wr;
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_rb_ctrl.sv
module uart_rb_ctrl
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              st_dlo,
  input  logic              st_dhi,
  input  logic              st_ien,
  input  logic              st_lcr,
  input  logic              st_mcr,
  input  logic              st_scr,
  output lcr_t              lcr,
  output logic [IEN_W-1:0]  int_en,
  output logic [MCR_W-1:0]  mcr,
  output logic [DATA_W-1:0] scratch,
  output logic [DATA_W-1:0] div_lo,
  output logic [DATA_W-1:0] div_hi
);
  lcr_t              lcr_q, lcr_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic [MCR_W-1:0]  mcr_q, mcr_d;
  logic [DATA_W-1:0] scr_q, scr_d;
  logic [DATA_W-1:0] dlo_q, dlo_d;
  logic [DATA_W-1:0] dhi_q, dhi_d;

  always_comb begin
    lcr_d = lcr_t'(wdata);
    ien_d = wdata[IEN_W-1:0];
    mcr_d = wdata[MCR_W-1:0];
    scr_d = wdata;
    dlo_d = wdata;
    dhi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      ien_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
    end else begin
      if (st_lcr) lcr_q <= lcr_d;
      if (st_ien) ien_q <= ien_d;
      if (st_mcr) mcr_q <= mcr_d;
      if (st_scr) scr_q <= scr_d;
      if (st_dlo) dlo_q <= dlo_d;
      if (st_dhi) dhi_q <= dhi_d;
    end
  end

  assign lcr     = lcr_q;
  assign int_en  = ien_q;
  assign mcr     = mcr_q;
  assign scratch = scr_q;
  assign div_lo  = dlo_q;
  assign div_hi  = dhi_q;
endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_thr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        wls,
  input  logic              ld_rbr,
  input  logic              ld_lsr,
  input  logic              tx_done,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  output logic [DATA_W-1:0] lsr,
  output logic [DATA_W-1:0] rx_buf,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_err
);
  logic thr_q, thr_d, tsr_q, tsr_d;
  logic dr_q, dr_d, ovr_q, ovr_d, pe_q, pe_d, fe_q, fe_d, bi_q, bi_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d, txb_q, txb_d;
  logic ld_q, ld_d, err_q, err_d;
  logic accept;

  assign accept = st_thr & thr_q;

  always_comb begin
    thr_d = thr_q;
    tsr_d = tsr_q;
    if (tx_done) begin
      thr_d = 1'b1;
      tsr_d = 1'b1;
    end
    if (accept) begin
      thr_d = 1'b0;
      tsr_d = 1'b0;
    end
    ld_d  = accept;
    err_d = st_thr & ~thr_q;
    txb_d = wdata & char_mask(wls);
    // arrivals take priority over read-clears
    dr_d   = (dr_q & ~ld_rbr) | rx_valid;
    ovr_d  = (ovr_q & ~ld_lsr) | (rx_valid & dr_q & ~ld_rbr);
    bi_d   = (bi_q & ~ld_lsr) | (rx_valid & rx_brk);
    pe_d   = rx_valid ? rx_perr : pe_q;
    fe_d   = rx_valid ? rx_ferr : fe_q;
    rbuf_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= 1'b1;
      tsr_q  <= 1'b1;
      dr_q   <= 1'b0;
      ovr_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
      rbuf_q <= '0;
      txb_q  <= '0;
      ld_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      thr_q <= thr_d;
      tsr_q <= tsr_d;
      dr_q  <= dr_d;
      ovr_q <= ovr_d;
      bi_q  <= bi_d;
      pe_q  <= pe_d;
      fe_q  <= fe_d;
      ld_q  <= ld_d;
      err_q <= err_d;
      if (rx_valid) rbuf_q <= rbuf_d;
      if (accept)   txb_q  <= txb_d;
    end
  end

  assign lsr     = {1'b0, tsr_q, thr_q, bi_q, fe_q, pe_q, ovr_q, dr_q};
  assign rx_buf  = rbuf_q;
  assign tx_load = ld_q;
  assign tx_byte = txb_q;
  assign tx_err  = err_q;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_err,
  input  logic              tx_done,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  output logic [DATA_W-1:0] line_ctrl,
  output logic [MCR_W-1:0]  modem_ctrl,
  output logic [DIV_W-1:0]  divisor
);
  logic st_thr, st_dlo, st_dhi, st_ien, st_lcr, st_mcr, st_scr;
  logic rbr_read, lsr_read;
  lcr_t              lcr;
  logic [IEN_W-1:0]  int_en;
  logic [DATA_W-1:0] scratch, div_lo, div_hi, lsr_val, rx_buf;

  uart_rb_decode u_dec (
    .acc_en (host_sel),
    .wr_en  (host_wr),
    .addr   (host_addr),
    .dlab   (lcr.dlab),
    .st_thr (st_thr),
    .st_dlo (st_dlo),
    .st_dhi (st_dhi),
    .st_ien (st_ien),
    .st_lcr (st_lcr),
    .st_mcr (st_mcr),
    .st_scr (st_scr),
    .ld_rbr (rbr_read),
    .ld_lsr (lsr_read)
  );

  uart_rb_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdata   (host_wdata),
    .st_dlo  (st_dlo),
    .st_dhi  (st_dhi),
    .st_ien  (st_ien),
    .st_lcr  (st_lcr),
    .st_mcr  (st_mcr),
    .st_scr  (st_scr),
    .lcr     (lcr),
    .int_en  (int_en),
    .mcr     (modem_ctrl),
    .scratch (scratch),
    .div_lo  (div_lo),
    .div_hi  (div_hi)
  );

  uart_rb_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_thr   (st_thr),
    .wdata    (host_wdata),
    .wls      (lcr.wls),
    .ld_rbr   (rbr_read),
    .ld_lsr   (lsr_read),
    .tx_done  (tx_done),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_perr  (rx_perr),
    .rx_ferr  (rx_ferr),
    .rx_brk   (rx_brk),
    .lsr      (lsr_val),
    .rx_buf   (rx_buf),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .tx_err   (tx_err)
  );

  always_comb begin
    case (ofs_e'(host_addr))
      OFS_DATA: host_rdata = lcr.dlab ? div_lo : rx_buf;
      OFS_IEN:  host_rdata = lcr.dlab ? div_hi : {{(DATA_W-IEN_W){1'b0}}, int_en};
      OFS_IID:  host_rdata = IID_IDLE;
      OFS_LCR:  host_rdata = lcr;
      OFS_MCR:  host_rdata = {{(DATA_W-MCR_W){1'b0}}, modem_ctrl};
      OFS_LSR:  host_rdata = lsr_val;
      OFS_SCR:  host_rdata = scratch;
      default:  host_rdata = '0;
    endcase
  end

  assign line_ctrl = lcr;
  assign divisor   = {div_hi, div_lo};
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic        host_wr,
  input logic [2:0]  host_addr,
  input logic [7:0]  host_wdata,
  input logic        tx_load,
  input logic [7:0]  tx_byte,
  input logic        tx_err,
  input logic        rx_valid,
  input logic [7:0]  line_ctrl,
  input logic [15:0] divisor,
  input logic [7:0]  lsr_val,
  input logic        rbr_read,
  input logic        lsr_read
);
  logic data_wr;
  assign data_wr = host_sel && host_wr && (host_addr == 3'd0);

  p_div_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && line_ctrl[7] |=> divisor[7:0] == $past(host_wdata));

  p_load_clears_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> lsr_val[6:5] == 2'b00);

  p_load_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (tx_byte & ~(8'hFF >> (2'd3 - line_ctrl[1:0]))) == 8'h00);

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !line_ctrl[7] && !lsr_val[5] |=> tx_err && !tx_load);

  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> !tx_load);

  p_rx_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> lsr_val[0]);

  p_rbr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_read && !rx_valid |=> !lsr_val[0]);

  p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && lsr_val[0] && !rbr_read |=> lsr_val[1]);

  p_lsr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_read && !rx_valid |=> !lsr_val[1] && !lsr_val[4]);
endmodule

bind uart_regbank uart_regbank_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .tx_load    (tx_load),
  .tx_byte    (tx_byte),
  .tx_err     (tx_err),
  .rx_valid   (rx_valid),
  .line_ctrl  (line_ctrl),
  .divisor    (divisor),
  .lsr_val    (lsr_val),
  .rbr_read   (rbr_read),
  .lsr_read   (lsr_read)
);

// File: tb/uart_regbank_tb_top.sv
`timescale 1ns/1ps
module uart_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        tx_load, tx_err, tx_done;
  logic [7:0]  tx_byte;
  logic        rx_valid, rx_perr, rx_ferr, rx_brk;
  logic [7:0]  rx_byte;
  logic [7:0]  line_ctrl;
  logic [4:0]  modem_ctrl;
  logic [15:0] divisor;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_load(tx_load), .tx_byte(tx_byte), .tx_err(tx_err), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_brk(rx_brk), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .divisor(divisor)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd3, 8'h83, 8'h00, 4'd2},  // R2 divisor access on, 8-bit chars
    '{1'b1, 3'd0, 8'h34, 8'h00, 4'd2},  // R2
    '{1'b1, 3'd1, 8'h12, 8'h00, 4'd2},  // R2
    '{1'b0, 3'd0, 8'h00, 8'h34, 4'd2},  // R2
    '{1'b0, 3'd1, 8'h00, 8'h12, 4'd2},  // R2
    '{1'b0, 3'd3, 8'h00, 8'h83, 4'd3},  // R3
    '{1'b1, 3'd3, 8'h5B, 8'h00, 4'd3},  // R3
    '{1'b0, 3'd3, 8'h00, 8'h5B, 4'd3},  // R3
    '{1'b0, 3'd1, 8'h00, 8'h00, 4'd3},  // R3 enables still 0
    '{1'b1, 3'd1, 8'hFF, 8'h00, 4'd3},  // R3
    '{1'b0, 3'd1, 8'h00, 8'h0F, 4'd3},  // R3
    '{1'b1, 3'd4, 8'hFF, 8'h00, 4'd3},  // R3
    '{1'b0, 3'd4, 8'h00, 8'h1F, 4'd3},  // R3
    '{1'b1, 3'd7, 8'hA5, 8'h00, 4'd4},  // R4
    '{1'b0, 3'd7, 8'h00, 8'hA5, 4'd4},  // R4
    '{1'b1, 3'd5, 8'h00, 8'h00, 4'd12}, // R12
    '{1'b0, 3'd5, 8'h00, 8'h60, 4'd12}, // R12
    '{1'b1, 3'd6, 8'hFF, 8'h00, 4'd12}, // R12
    '{1'b0, 3'd6, 8'h00, 8'h00, 4'd12}, // R12
    '{1'b1, 3'd2, 8'hFF, 8'h00, 4'd12}, // R12
    '{1'b0, 3'd2, 8'h00, 8'h01, 4'd12}, // R12
    '{1'b1, 3'd3, 8'h80, 8'h00, 4'd2},  // R2
    '{1'b0, 3'd0, 8'h00, 8'h34, 4'd2},  // R2 divisor kept
    '{1'b0, 3'd1, 8'h00, 8'h12, 4'd2},  // R2
    '{1'b1, 3'd3, 8'h03, 8'h00, 4'd3}   // R3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 chk(tag, host_rdata, exp);
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    tx_done = 1'b0; rx_valid = 1'b0; rx_byte = '0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(3'd0, 8'h00, "R1 ofs0");
    bus_rd(3'd1, 8'h00, "R1 ofs1");
    bus_rd(3'd2, 8'h01, "R1 ofs2");
    bus_rd(3'd3, 8'h00, "R1 ofs3");
    bus_rd(3'd4, 8'h00, "R1 ofs4");
    bus_rd(3'd5, 8'h60, "R1 ofs5");
    bus_rd(3'd6, 8'h00, "R1 ofs6");
    bus_rd(3'd7, 8'h00, "R1 ofs7");
    #1;
    chk("R1 tx_load", tx_load, 0);
    chk("R1 tx_err", tx_err, 0);
    chk("R1 divisor", divisor, 0);
    chk("R1 line_ctrl", line_ctrl, 0);
    chk("R1 modem_ctrl", modem_ctrl, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].a, VEC[i].d);
      else bus_rd(VEC[i].a, VEC[i].exp, $sformatf("R%0d row %0d", VEC[i].req, i));
    end
    #1;
    chk("R2 divisor port", divisor, 16'h1234);
    chk("R3 modem_ctrl port", modem_ctrl, 5'h1F);
    chk("R3 line_ctrl port", line_ctrl, 8'h03);

    // R5 R6 transmit with 5-bit characters
    bus_wr(3'd3, 8'h00);
    bus_wr(3'd0, 8'hFF);
    #1;
    chk("R5 tx_load", tx_load, 1);
    chk("R6 tx_byte 5-bit", tx_byte, 8'h1F);
    bus_rd(3'd5, 8'h00, "R5 empty flags cleared");
    // R7 write while full
    bus_wr(3'd0, 8'hAA);
    #1;
    chk("R7 tx_err", tx_err, 1);
    chk("R7 no tx_load", tx_load, 0);
    @(negedge clk); #1;
    chk("R7 tx_err one cycle", tx_err, 0);
    // R8
    done_pulse();
    bus_rd(3'd5, 8'h60, "R8 done sets empty");
    // R6 7-bit characters
    bus_wr(3'd3, 8'h02);
    bus_wr(3'd0, 8'hFF);
    #1;
    chk("R6 tx_byte 7-bit", tx_byte, 8'h7F);
    done_pulse();
    bus_wr(3'd3, 8'h03);

    // R9 receive with parity error and break
    rx_push(8'h5A, 1'b1, 1'b0, 1'b1);
    bus_rd(3'd5, 8'h75, "R9 status after arrival");
    bus_rd(3'd5, 8'h65, "R11 break cleared, parity kept");
    bus_rd(3'd0, 8'h5A, "R9 buffer");
    bus_rd(3'd5, 8'h64, "R10 ready cleared");
    // R10 read with divisor access on
    rx_push(8'h11, 1'b0, 1'b0, 1'b0);
    bus_wr(3'd3, 8'h83);
    bus_rd(3'd0, 8'h34, "R10 divisor at ofs0");
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd5, 8'h61, "R10 ready kept");
    // R11 overrun
    rx_push(8'h22, 1'b0, 1'b0, 1'b0);
    bus_rd(3'd0, 8'h22, "R11 newest byte");
    bus_rd(3'd5, 8'h62, "R11 overrun set");
    bus_rd(3'd5, 8'h60, "R11 overrun cleared");

    // R13 arrival meets buffer read
    rx_push(8'h33, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = 3'd0;
    rx_valid = 1'b1; rx_byte = 8'h44;
    #1 chk("R13 old byte read", host_rdata, 8'h33);
    @(negedge clk);
    host_sel = 1'b0; rx_valid = 1'b0;
    bus_rd(3'd5, 8'h61, "R13 ready stays, no overrun");
    bus_rd(3'd0, 8'h44, "R13 new byte");
    // R13 break meets status read
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = 3'd5;
    rx_valid = 1'b1; rx_byte = 8'h00; rx_brk = 1'b1;
    #1 chk("R13 status before", host_rdata, 8'h60);
    @(negedge clk);
    host_sel = 1'b0; rx_valid = 1'b0; rx_brk = 1'b0;
    bus_rd(3'd5, 8'h71, "R13 break survives");
    bus_rd(3'd5, 8'h61, "R11 break cleared");

    // R1 second reset
    bus_wr(3'd7, 8'h5C);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_rd(3'd7, 8'h00, "R1 scratch after reset");
    bus_rd(3'd5, 8'h60, "R1 status after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule